// File: doc/BRIEF.md
# Receive FIFO with Trigger Level and Character Timeout

This block holds the bytes delivered by a serial receiver until software reads them through the receive buffer port. It keeps up to sixteen bytes in arrival order. It reports data-ready, break, overrun and trigger-level status. It also raises a character-timeout flag when bytes sit unread while the line is quiet.

A FIFO control byte configures the block. The two top bits choose a trigger threshold. Bit 1 flushes the receive side. Bit 2 asks the neighbouring transmit queue to flush, and the block drives a pulse for that. Changing the enable bit flushes both queues. The timeout window is four character times, measured in bit-time ticks. The length of one character follows from the line-control field that sets data bits, parity and stop bits.

Top module: `rx_fifo_trig`

## Requirements
- R1: The queue holds up to 16 bytes and returns them oldest first. `rd_data_o` shows the oldest byte whenever `level_o` is non-zero and shows 0 when the queue is empty. A read of an empty queue changes nothing.
- R2: A byte pushed while the queue holds 16 bytes and no read occurs in the same cycle is dropped. The level stays at 16 and `overrun_o` goes high. The overrun flag is cleared only by a receive flush.
- R3: Control bits 7:6 select the trigger threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. With enable (bit 0) set, `trigger_o` is high exactly when the level is at or above the threshold. With enable clear, `trigger_o` is high whenever any byte is held.
- R4: A control write keeps only bits 7, 6, 3 and 0 (mask 0xC9). `cfg_o` shows the kept value from the cycle after the write.
- R5: A control write with bit 1 set empties the queue and clears the timeout, break and overrun flags.
- R6: A control write with bit 2 set drives `tx_flush_o` high during the write cycle.
- R7: A control write whose bit 0 differs from the kept enable bit drives `tx_flush_o` and empties the receive queue, whatever bits 1 and 2 hold.
- R8: A break event pushes a zero byte and sets `break_o`. `data_ready_o` is high whenever `level_o` is non-zero.
- R9: A read that takes the last byte clears both `data_ready_o` and `break_o`.
- R10: Every accepted byte, and every read that leaves bytes behind, restarts a window of 4 × N bit ticks. N = 1 + (lcr_i[1:0] + 5) + lcr_i[3] + (lcr_i[2] ? 2 : 1). When the window ends, `timeout_o` is set only if the queue is not empty.
- R11: Any read clears `timeout_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | FIFO control write strobe |
| cfg_wdata_i | input | 8 | FIFO control write value |
| lcr_i | input | 4 | Line control: [1:0] data bits minus 5, [2] two stop bits, [3] parity present |
| bit_tick_i | input | 1 | One pulse per bit time |
| rx_valid_i | input | 1 | Byte from the deserializer is valid |
| rx_data_i | input | 8 | Byte from the deserializer |
| break_i | input | 1 | Break condition received |
| rd_i | input | 1 | Receive buffer read strobe (pops one byte) |
| rd_data_o | output | 8 | Oldest byte, or 0 when empty |
| cfg_o | output | 8 | Kept control bits |
| tx_flush_o | output | 1 | Flush request to the transmit queue |
| level_o | output | 5 | Bytes held |
| data_ready_o | output | 1 | Queue not empty |
| break_o | output | 1 | Break received and not yet drained |
| overrun_o | output | 1 | A byte was dropped on a full queue |
| trigger_o | output | 1 | Level has reached the threshold |
| timeout_o | output | 1 | Character timeout pending |

## Verification
The assertions hold every cycle for the invariants that link the flags to the level. They check that break and timeout imply a non-empty queue and that an empty queue shows no data-ready. They also check that flushes, including the enable toggle, empty the queue on the next cycle, that the kept control value is masked, that a read clears the timeout, and that a push into a full queue is dropped with overrun. Only the bench scenarios can show the oldest-first order, the exact threshold for each selector, and the window length for all sixteen line-control settings. They also show the window restarting on a read that leaves data behind, and no timeout when the queue drained before the window ended.

// File: rtl/rx_fifo_trig_pkg.sv
package rx_fifo_trig_pkg;

  localparam int unsigned THR_W = 5;

  // threshold in bytes for the selector in control bits 7:6
  function automatic logic [THR_W-1:0] thr_of(input logic [1:0] sel);
    case (sel)
      2'd0:    thr_of = 5'd1;
      2'd1:    thr_of = 5'd4;
      2'd2:    thr_of = 5'd8;
      default: thr_of = 5'd14;
    endcase
  endfunction

  localparam logic [7:0] CFG_KEEP_MASK = 8'hC9;

endpackage

// File: rtl/rx_fifo_trig_store.sv
module rx_fifo_trig_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_nx, rp_nx;
  logic [CW-1:0] cnt_q;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wp_nx = wp_q + AW'(1);
      assign rp_nx = rp_q + AW'(1);
    end else begin : g_wrap
      assign wp_nx = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      assign rp_nx = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_nx;
      if (pop_i)  rp_q <= rp_nx;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wp_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;

endmodule

// File: rtl/rx_fifo_trig_chartime.sv
module rx_fifo_trig_chartime #(
  parameter int unsigned CHARS = 4,
  parameter int unsigned LIM_W = $clog2(12 * CHARS + 1)
) (
  input  logic [3:0]       lcr_i,
  output logic [LIM_W-1:0] limit_o
);

  logic [3:0] bits;

  // start + 5 data + 1 stop = 7, then extras
  always_comb begin
    bits    = 4'd7 + {2'b00, lcr_i[1:0]} + {3'b000, lcr_i[3]} + {3'b000, lcr_i[2]};
    limit_o = LIM_W'(32'(bits) * CHARS);
  end

endmodule

// File: rtl/rx_fifo_trig_timer.sv
module rx_fifo_trig_timer #(
  parameter int unsigned LIM_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             cancel_i,
  input  logic             tick_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             expire_o
);

  logic             armed_q;
  logic [LIM_W-1:0] cnt_q;
  logic             last;

  assign last     = cnt_q >= (limit_i - LIM_W'(1));
  assign expire_o = armed_q && tick_i && last && !restart_i && !cancel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cancel_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (restart_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q && tick_i) begin
      if (last) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + LIM_W'(1);
      end
    end
  end

endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig
  import rx_fifo_trig_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned TO_CHARS = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic [7:0]                   cfg_wdata_i,
  input  logic [3:0]                   lcr_i,
  input  logic                         bit_tick_i,
  input  logic                         rx_valid_i,
  input  logic [DW-1:0]                rx_data_i,
  input  logic                         break_i,
  input  logic                         rd_i,
  output logic [DW-1:0]                rd_data_o,
  output logic [7:0]                   cfg_o,
  output logic                         tx_flush_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o,
  output logic                         data_ready_o,
  output logic                         break_o,
  output logic                         overrun_o,
  output logic                         trigger_o,
  output logic                         timeout_o
);

  localparam int unsigned CW    = $clog2(DEPTH + 1);
  localparam int unsigned LIM_W = $clog2(12 * TO_CHARS + 1);

  logic [7:0]       cfg_q;
  logic             en_toggle, rx_flush;
  logic             push_req, push, pop, restart, expire;
  logic [DW-1:0]    push_data, head;
  logic [CW-1:0]    cnt, cnt_nx;
  logic [LIM_W-1:0] limit;
  logic             brk_q, ovr_q, to_q;

  // control decode
  assign en_toggle  = cfg_we_i && (cfg_wdata_i[0] != cfg_q[0]);
  assign rx_flush   = cfg_we_i && (cfg_wdata_i[1] || en_toggle);
  assign tx_flush_o = cfg_we_i && (cfg_wdata_i[2] || en_toggle);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i & CFG_KEEP_MASK;
  end

  // push / pop arbitration; a break carries a zero byte
  assign push_req  = (rx_valid_i || break_i) && !rx_flush;
  assign push_data = break_i ? '0 : rx_data_i;
  assign pop       = rd_i && (cnt != '0) && !rx_flush;
  assign push      = push_req && ((cnt < CW'(DEPTH)) || pop);
  assign cnt_nx    = cnt + CW'(push) - CW'(pop);
  assign restart   = push || (pop && (cnt_nx != '0));

  rx_fifo_trig_store #(
    .DEPTH (DEPTH),
    .DW    (DW)
  ) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_flush),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (push_data),
    .rdata_o (head),
    .count_o (cnt)
  );

  rx_fifo_trig_chartime #(
    .CHARS (TO_CHARS),
    .LIM_W (LIM_W)
  ) i_chartime (
    .lcr_i   (lcr_i),
    .limit_o (limit)
  );

  rx_fifo_trig_timer #(
    .LIM_W (LIM_W)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .cancel_i  (rx_flush),
    .tick_i    (bit_tick_i),
    .limit_i   (limit),
    .expire_o  (expire)
  );

  // status flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q <= 1'b0;
      ovr_q <= 1'b0;
      to_q  <= 1'b0;
    end else if (rx_flush) begin
      brk_q <= 1'b0;
      ovr_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      if (push && break_i)               brk_q <= 1'b1;
      else if (pop && (cnt_nx == '0))    brk_q <= 1'b0;
      if (push_req && !push)             ovr_q <= 1'b1;
      if (rd_i)                          to_q  <= 1'b0;
      else if (expire && (cnt_nx != '0)) to_q  <= 1'b1;
    end
  end

  assign rd_data_o    = (cnt != '0) ? head : '0;
  assign cfg_o        = cfg_q;
  assign level_o      = cnt;
  assign data_ready_o = (cnt != '0);
  assign break_o      = brk_q;
  assign overrun_o    = ovr_q;
  assign timeout_o    = to_q;
  assign trigger_o    = cfg_q[0] ? (32'(cnt) >= 32'(thr_of(cfg_q[7:6]))) : (cnt != '0);

endmodule

// File: rtl/rx_fifo_trig_chk.sv
module rx_fifo_trig_chk #(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned TO_CHARS = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       cfg_we_i,
  input logic [7:0]                 cfg_wdata_i,
  input logic [3:0]                 lcr_i,
  input logic                       bit_tick_i,
  input logic                       rx_valid_i,
  input logic [DW-1:0]              rx_data_i,
  input logic                       break_i,
  input logic                       rd_i,
  input logic [DW-1:0]              rd_data_o,
  input logic [7:0]                 cfg_o,
  input logic                       tx_flush_o,
  input logic [$clog2(DEPTH+1)-1:0] level_o,
  input logic                       data_ready_o,
  input logic                       break_o,
  input logic                       overrun_o,
  input logic                       trigger_o,
  input logic                       timeout_o
);

  a_r1_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(level_o) <= DEPTH);

  a_r1_empty_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0) |-> (rd_data_o == '0));

  a_r2_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(level_o) == DEPTH && rx_valid_i && !rd_i && !cfg_we_i)
      |=> (overrun_o && 32'(level_o) == DEPTH));

  a_r4_cfg_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cfg_o == ($past(cfg_wdata_i) & 8'hC9)));

  a_r5_rx_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[1]) |=> (level_o == '0 && !timeout_o && !overrun_o && !break_o));

  a_r6_tx_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[2]) |-> tx_flush_o);

  a_r7_toggle_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && (cfg_wdata_i[0] != cfg_o[0])) |-> tx_flush_o);

  a_r7_toggle_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && (cfg_wdata_i[0] != cfg_o[0])) |=> (level_o == '0));

  a_r8_ready_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o == (level_o != '0));

  a_r9_break_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |-> data_ready_o);

  a_r10_timeout_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (level_o != '0));

  a_r11_read_clears_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !timeout_o);

endmodule

bind rx_fifo_trig rx_fifo_trig_chk #(
  .DEPTH    (DEPTH),
  .DW       (DW),
  .TO_CHARS (TO_CHARS)
) i_rx_fifo_trig_chk (.*);

// File: tb/test_rx_fifo_trig.sv
module test_rx_fifo_trig;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [3:0] lcr_i = '0;
  logic       bit_tick_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       break_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [7:0] cfg_o;
  logic       tx_flush_o;
  logic [4:0] level_o;
  logic       data_ready_o, break_o, overrun_o, trigger_o, timeout_o;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rx_fifo_trig i_rx_fifo_trig (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .lcr_i, .bit_tick_i,
    .rx_valid_i, .rx_data_i, .break_i, .rd_i, .rd_data_o, .cfg_o,
    .tx_flush_o, .level_o, .data_ready_o, .break_o, .overrun_o,
    .trigger_o, .timeout_o
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic cfg_write(input logic [7:0] v, input int exp_txf);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    #1 check("R6/R7 tx flush pulse", int'(tx_flush_o), exp_txf);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_data_i = b;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic brk();
    @(negedge clk_i);
    break_i = 1'b1; rx_data_i = 8'hAA;
    @(negedge clk_i);
    break_i = 1'b0;
  endtask

  task automatic rd(input string req, input int exp);
    @(negedge clk_i);
    check(req, int'(rd_data_o), exp);
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      bit_tick_i = 1'b1;
    end
    @(negedge clk_i);
    bit_tick_i = 1'b0;
  endtask

  function automatic int thr(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state
    check("R1 reset level", int'(level_o), 0);
    check("R1 reset rd_data", int'(rd_data_o), 0);
    check("R8 reset ready", int'(data_ready_o), 0);
    check("R4 reset cfg", int'(cfg_o), 0);
    check("R11 reset timeout", int'(timeout_o), 0);

    // R7: enabling toggles bit 0
    cfg_write(8'h01, 1);
    check("R4 cfg after enable", int'(cfg_o), 1);
    // R4 mask, R6 bit2
    cfg_write(8'hFF, 1);
    check("R4 kept bits", int'(cfg_o), 8'hC9);

    // R3 threshold sweep with R1 order and R2 overrun
    for (int t = 0; t < 4; t++) begin
      cfg_write(8'((t << 6) | 3), 0);
      check("R5 flush empties", int'(level_o), 0);
      check("R5 flush clears overrun", int'(overrun_o), 0);
      for (int k = 1; k <= DEPTH; k++) begin
        push(8'(t * 37 + k));
        check("R1 level", int'(level_o), k);
        check("R3 trigger", int'(trigger_o), int'(k >= thr(t)));
      end
      check("R2 no overrun yet", int'(overrun_o), 0);
      push(8'hEE);
      check("R2 level held", int'(level_o), DEPTH);
      check("R2 overrun set", int'(overrun_o), 1);
      for (int k = 1; k <= DEPTH; k++) rd("R1 order", t * 37 + k);
      check("R9 drained ready", int'(data_ready_o), 0);
      check("R2 overrun sticky", int'(overrun_o), 1);
      rd("R1 empty read zero", 0);
      check("R1 empty read level", int'(level_o), 0);
    end

    // R3 with enable clear, then R7 toggle back
    cfg_write(8'h00, 1);
    push(8'h11);
    check("R3 disabled trigger", int'(trigger_o), 1);
    push(8'h22);
    check("R1 level two", int'(level_o), 2);
    cfg_write(8'h01, 1);
    check("R7 toggle empties", int'(level_o), 0);

    // R8 break, R9 drain
    push(8'h55);
    brk();
    check("R8 break level", int'(level_o), 2);
    check("R8 break flag", int'(break_o), 1);
    check("R8 ready", int'(data_ready_o), 1);
    rd("R1 before break", 8'h55);
    check("R9 break kept", int'(break_o), 1);
    rd("R8 zero byte", 0);
    check("R9 break cleared", int'(break_o), 0);
    check("R9 ready cleared", int'(data_ready_o), 0);

    // R10 window for all line-control settings, R11 read clears
    for (int l = 0; l < 16; l++) begin
      int lim;
      lim = 4 * (1 + 5 + (l & 3) + ((l >> 3) & 1) + (((l >> 2) & 1) ? 2 : 1));
      lcr_i = 4'(l);
      cfg_write(8'h03, 0);
      push(8'(l));
      tick(lim - 1);
      check("R10 before window end", int'(timeout_o), 0);
      tick(1);
      check("R10 window end", int'(timeout_o), 1);
      rd("R1 timeout byte", l);
      check("R11 read clears", int'(timeout_o), 0);
    end

    // R10 restart on a read that leaves data
    lcr_i = 4'd0;
    cfg_write(8'h03, 0);
    push(8'h31);
    push(8'h32);
    tick(27);
    rd("R1 restart read", 8'h31);
    tick(27);
    check("R10 restarted window", int'(timeout_o), 0);
    tick(1);
    check("R10 restarted expiry", int'(timeout_o), 1);
    rd("R1 last byte", 8'h32);

    // R10 no timeout after drain
    push(8'h40);
    tick(10);
    rd("R1 drain byte", 8'h40);
    tick(40);
    check("R10 empty no timeout", int'(timeout_o), 0);

    summary();
  end

endmodule